// File: doc/BRIEF.md
# Serial-Bus Nonvolatile Byte Memory Slave

This block is a synthesizable behavioural model of a 1024-byte serial nonvolatile memory that answers a host over a four-wire synchronous serial bus. The host selects the block with an active-low select, clocks commands in most significant bit first, and reads results back on a serial output that the block drives only while it has data to return. The model keeps the array in on-chip flip-flops. A bounded counter on the system clock stands in for the self-timed programming cycle.

The serial pins are sampled with the system clock, so the serial clock must run several times slower than it. The block takes six one-byte commands: arm writes, disarm writes, read status, write status, read array and write array. Array writes collect up to one page of bytes, which are programmed after the select returns high. A two-bit guard level in status locks part or all of the array. A status bit can hand control of status writes to an external lock pin. A pause pin freezes a transfer part-way through.

Top module: `spi_eeprom`

## Requirements
- R1: Serial data is captured on rising serial-clock edges and the output changes only after falling edges, so both idle-low (mode 0) and idle-high (mode 3) clocking work; every field moves most significant bit first.
- R2: Opcode 0x06 sets the write-armed bit and 0x04 clears it; opcode 0x05 streams the status byte repeatedly, with bit 7 = pin-lock, bits 6:4 = 0, bits 3:2 = guard level, bit 1 = write-armed, bit 0 = busy.
- R3: Array write (0x02) and status write (0x01) have no effect unless the write-armed bit is set.
- R4: Opcode 0x03 followed by a 16-bit address (only the low 10 bits count) returns bytes from consecutive addresses, and the address rolls over from 1023 to 0.
- R5: Array-write data goes to consecutive addresses and wraps within the 32-byte page of the start address. The bytes are programmed only if the select rises on a byte boundary; a trailing partial byte cancels the whole write.
- R6: An accepted write sets busy as soon as the select rises. Busy stays set for WR_CYCLES system clocks, and the write-armed bit clears when it ends.
- R7: While busy, every opcode except status read is ignored: the output stays undriven and no state changes.
- R8: An array write whose start address is locked is ignored. Guard level 0 locks nothing, 1 locks 768–1023, 2 locks 512–1023, and 3 locks all addresses.
- R9: With pin-lock set and the lock pin low, status writes are ignored. With pin-lock clear, the lock pin has no effect.
- R10: When the pause pin is pulled low while the serial clock is low, the output floats and clock and data are ignored. Releasing it with the clock low resumes the transfer at the same bit.
- R11: An unknown opcode leaves the output undriven for the rest of the frame, and the rest of that frame has no effect.
- R12: After reset the status byte reads 0x00, every array byte reads 0xFF and the output is undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins and times the write cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block |
| miso_oe | output | 1 | High while miso should be driven onto the bus |
| wprot_n | input | 1 | Active-low lock pin for status writes |
| pause_n | input | 1 | Active-low transfer pause |

## Verification
Reads and page writes are run with the serial clock idling both low and high, and the two give different results if an edge is taken with the wrong polarity. Page writes start near the end of a page and run past it, which separates wrap-within-page from plain increment; a read that crosses address 1023 checks the rollover of the whole array. Each guard level is swept against a probe write into each quarter, so that every level is compared with every region. The pin-lock bit is tried with the lock pin both high and low, and a partial trailing byte, an unknown opcode and a pause in the middle of a byte each show that the block leaves state alone or resumes at the same bit.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

  typedef enum logic [1:0] {
    PH_OPC,
    PH_ADDR,
    PH_DATA,
    PH_SKIP
  } phase_t;

  localparam logic [7:0] OP_STAT_WR = 8'h01;
  localparam logic [7:0] OP_MEM_WR  = 8'h02;
  localparam logic [7:0] OP_MEM_RD  = 8'h03;
  localparam logic [7:0] OP_DISARM  = 8'h04;
  localparam logic [7:0] OP_STAT_RD = 8'h05;
  localparam logic [7:0] OP_ARM     = 8'h06;

  // Guard level decode: 0 none, 1 top quarter, 2 top half, 3 everything.
  function automatic logic is_locked(input logic [1:0] lvl,
                                     input int unsigned addr,
                                     input int unsigned depth);
    case (lvl)
      2'd0:    return 1'b0;
      2'd1:    return addr >= depth - depth / 4;
      2'd2:    return addr >= depth / 2;
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/spi_ee_link.sv
module spi_ee_link (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  input  logic sclk,
  input  logic pause_n,
  output logic rise_evt,
  output logic fall_evt,
  output logic frame_go,
  output logic frame_end,
  output logic hold_act
);
  logic sclk_q;
  logic sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q   <= 1'b0;
      sel_q    <= 1'b1;
      hold_act <= 1'b0;
    end else begin
      sclk_q <= sclk;
      sel_q  <= sel_n;
      if (sel_n)
        hold_act <= 1'b0;
      else if (!hold_act && !pause_n && !sclk)
        hold_act <= 1'b1;
      else if (hold_act && pause_n && !sclk)
        hold_act <= 1'b0;
    end
  end

  assign frame_go  = sel_q & ~sel_n;
  assign frame_end = ~sel_q & sel_n;
  assign rise_evt  = ~sel_n & ~hold_act & sclk & ~sclk_q;
  assign fall_evt  = ~sel_n & ~hold_act & ~sclk & sclk_q;
endmodule

// File: rtl/spi_ee_wtimer.sv
module spi_ee_wtimer #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= CW'(CYCLES - 1);
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array #(
  parameter int DEPTH = 1024,
  parameter int PAGE  = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             commit,
  input  logic [$clog2(DEPTH)-$clog2(PAGE)-1:0] page_idx,
  input  logic [PAGE-1:0][7:0]             pbuf,
  input  logic [PAGE-1:0]                  pmask,
  input  logic [$clog2(DEPTH)-1:0]         raddr,
  output logic [7:0]                       rdata
);
  localparam int OW = $clog2(PAGE);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (commit) begin
      for (int i = 0; i < PAGE; i++)
        if (pmask[i]) mem[{page_idx, OW'(i)}] <= pbuf[i];
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/spi_eeprom.sv
module spi_eeprom #(
  parameter int DEPTH      = 1024,
  parameter int PAGE       = 32,
  parameter int WR_CYCLES  = 1000,
  parameter int ADDR_FIELD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  input  logic sclk,
  input  logic mosi,
  output logic miso,
  output logic miso_oe,
  input  logic wprot_n,
  input  logic pause_n
);
  import spi_ee_pkg::*;

  localparam int AW         = $clog2(DEPTH);
  localparam int OW         = $clog2(PAGE);
  localparam int PGW        = AW - OW;
  localparam int ADDR_BYTES = ADDR_FIELD / 8;
  localparam int ABW        = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

  function automatic logic [AW-1:0] page_step(input logic [AW-1:0] a);
    return {a[AW-1:OW], a[OW-1:0] + OW'(1)};
  endfunction

  // Named events for the checker
  logic rise_evt, fall_evt, frame_go, frame_end, hold_act;
  logic busy, wcyc_start, wcyc_done, in_skip;

  phase_t          ph;
  logic [2:0]      bitc;
  logic [6:0]      rx;
  logic [7:0]      opc;
  logic [ABW-1:0]  abyte;
  logic [AW-1:0]   addr_sh;
  logic [AW-1:0]   ptr;
  logic [PAGE-1:0][7:0] pbuf;
  logic [PAGE-1:0] pmask;
  logic            pend_mem, pend_st, kind_st;
  logic            new_lock;
  logic [1:0]      new_lvl;
  logic            wr_armed, pin_lock;
  logic [1:0]      guard_lvl;
  logic [6:0]      tx_sh;
  logic            so_r, so_en;
  logic [7:0]      rdata;

  wire [7:0]    rx_next  = {rx, mosi};
  wire [AW-1:0] addr_new = AW'({addr_sh, rx_next});
  wire [7:0]    st_byte  = {pin_lock, 3'b000, guard_lvl, wr_armed, busy};
  wire          rd_op    = (opc == OP_MEM_RD) || (opc == OP_STAT_RD);
  wire [7:0]    tx_src   = (opc == OP_MEM_RD) ? rdata : st_byte;

  assign in_skip    = (ph == PH_SKIP);
  assign wcyc_start = frame_end && (pend_mem || pend_st) && (bitc == 3'd0) && !busy;

  spi_ee_link link_i (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .pause_n(pause_n),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .frame_go(frame_go),
    .frame_end(frame_end), .hold_act(hold_act)
  );

  spi_ee_wtimer #(.CYCLES(WR_CYCLES)) tmr_i (
    .clk(clk), .rst_n(rst_n), .start(wcyc_start), .busy(busy), .done(wcyc_done)
  );

  spi_ee_array #(.DEPTH(DEPTH), .PAGE(PAGE)) arr_i (
    .clk(clk), .rst_n(rst_n), .commit(wcyc_done && !kind_st),
    .page_idx(ptr[AW-1:OW]), .pbuf(pbuf), .pmask(pmask),
    .raddr(ptr), .rdata(rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_SKIP;
      bitc      <= '0;
      rx        <= '0;
      opc       <= '0;
      abyte     <= '0;
      addr_sh   <= '0;
      ptr       <= '0;
      pbuf      <= '0;
      pmask     <= '0;
      pend_mem  <= 1'b0;
      pend_st   <= 1'b0;
      kind_st   <= 1'b0;
      new_lock  <= 1'b0;
      new_lvl   <= '0;
      wr_armed  <= 1'b0;
      pin_lock  <= 1'b0;
      guard_lvl <= '0;
      tx_sh     <= '0;
      so_r      <= 1'b0;
      so_en     <= 1'b0;
    end else begin
      if (frame_go) begin
        ph       <= PH_OPC;
        bitc     <= '0;
        abyte    <= '0;
        pend_mem <= 1'b0;
        pend_st  <= 1'b0;
        so_en    <= 1'b0;
        if (!busy) pmask <= '0;
      end else if (frame_end) begin
        so_en <= 1'b0;
      end else begin
        if (rise_evt) begin
          rx   <= rx_next[6:0];
          bitc <= bitc + 3'd1;
          if (bitc == 3'd7) begin
            case (ph)
              PH_OPC: begin
                opc <= rx_next;
                if (busy && rx_next != OP_STAT_RD) ph <= PH_SKIP;
                else begin
                  case (rx_next)
                    OP_ARM:     begin wr_armed <= 1'b1; ph <= PH_SKIP; end
                    OP_DISARM:  begin wr_armed <= 1'b0; ph <= PH_SKIP; end
                    OP_STAT_RD: ph <= PH_DATA;
                    OP_STAT_WR: ph <= PH_DATA;
                    OP_MEM_RD:  ph <= PH_ADDR;
                    OP_MEM_WR:  ph <= PH_ADDR;
                    default:    ph <= PH_SKIP;
                  endcase
                end
              end
              PH_ADDR: begin
                addr_sh <= addr_new;
                abyte   <= abyte + 1'b1;
                if (abyte == ABW'(ADDR_BYTES - 1)) begin
                  ptr <= addr_new;
                  if (opc == OP_MEM_WR &&
                      (!wr_armed || is_locked(guard_lvl, 32'(addr_new), DEPTH)))
                    ph <= PH_SKIP;
                  else
                    ph <= PH_DATA;
                end
              end
              PH_DATA: begin
                if (opc == OP_MEM_WR) begin
                  pbuf[ptr[OW-1:0]]  <= rx_next;
                  pmask[ptr[OW-1:0]] <= 1'b1;
                  pend_mem           <= 1'b1;
                  ptr                <= page_step(ptr);
                end else if (opc == OP_MEM_RD) begin
                  ptr <= ptr + 1'b1;
                end else if (opc == OP_STAT_WR) begin
                  if (wr_armed && !(pin_lock && !wprot_n)) begin
                    new_lock <= rx_next[7];
                    new_lvl  <= rx_next[3:2];
                    pend_st  <= 1'b1;
                  end
                  ph <= PH_SKIP;
                end
              end
              default: ;
            endcase
          end
        end
        if (fall_evt && ph == PH_DATA && rd_op) begin
          so_en <= 1'b1;
          if (bitc == 3'd0) begin
            so_r  <= tx_src[7];
            tx_sh <= tx_src[6:0];
          end else begin
            so_r  <= tx_sh[6];
            tx_sh <= {tx_sh[5:0], 1'b0};
          end
        end
      end
      if (wcyc_start) kind_st <= pend_st;
      if (wcyc_done) begin
        wr_armed <= 1'b0;
        pmask    <= '0;
        if (kind_st) begin
          pin_lock  <= new_lock;
          guard_lvl <= new_lvl;
        end
      end
    end
  end

  assign miso    = so_r;
  assign miso_oe = so_en & ~hold_act & ~sel_n;

  logic unused_pgw;
  assign unused_pgw = (PGW > 0);
endmodule

// File: rtl/spi_eeprom_chk.sv
module spi_eeprom_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       miso_oe,
  input logic       fall_evt,
  input logic       hold_act,
  input logic       wcyc_start,
  input logic       wcyc_done,
  input logic       busy,
  input logic       wr_armed,
  input logic [1:0] guard_lvl,
  input logic       pin_lock,
  input logic       in_skip
);
  // R6
  armed_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wcyc_done |=> !wr_armed);

  // R6
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wcyc_start |=> busy);

  // R9
  status_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wcyc_done |=> ($stable(guard_lvl) && $stable(pin_lock)));

  // R1
  drive_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miso_oe) |-> ($past(fall_evt) || $past(hold_act)));

  // R11
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_skip |-> !miso_oe);
endmodule

bind spi_eeprom spi_eeprom_chk chk_i (
  .clk(clk), .rst_n(rst_n), .miso_oe(miso_oe), .fall_evt(fall_evt),
  .hold_act(hold_act), .wcyc_start(wcyc_start), .wcyc_done(wcyc_done),
  .busy(busy), .wr_armed(wr_armed), .guard_lvl(guard_lvl),
  .pin_lock(pin_lock), .in_skip(in_skip)
);

// File: tb/spi_eeprom_tb_top.sv
module spi_eeprom_tb_top;
  localparam int WRC  = 300;
  localparam int HALF = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, sel_n, sclk, mosi, wprot_n, pause_n;
  wire  miso, miso_oe;

  spi_eeprom #(.WR_CYCLES(WRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .wprot_n(wprot_n), .pause_n(pause_n)
  );

  int n_run = 0, n_fail = 0, cyc = 0;
  bit finished = 0;
  logic [7:0] model [1024];
  logic [7:0] wbuf [16];
  logic cpol = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_lo();
    sclk = cpol; tick(2); sel_n = 1'b0; tick(HALF);
  endtask

  task automatic cs_hi();
    sclk = cpol; tick(HALF); sel_n = 1'b1; tick(HALF + 2);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output bit oe);
    oe = 0;
    for (int b = 7; b >= 0; b--) begin
      sclk = 1'b0; mosi = tx[b]; tick(HALF);
      rx[b] = miso; oe |= miso_oe;
      sclk = 1'b1; tick(HALF);
    end
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r; bit oe;
    cs_lo(); xfer(op, r, oe); cs_hi();
  endtask

  task automatic rd_stat(output logic [7:0] s);
    bit oe; logic [7:0] r;
    cs_lo(); xfer(8'h05, r, oe); xfer(8'h00, s, oe); cs_hi();
  endtask

  task automatic wait_ready();
    logic [7:0] s;
    for (int i = 0; i < 60; i++) begin
      rd_stat(s);
      if (!s[0]) return;
    end
  endtask

  task automatic wr_stat(input logic [7:0] v);
    logic [7:0] r; bit oe;
    cs_lo(); xfer(8'h01, r, oe); xfer(v, r, oe); cs_hi();
  endtask

  task automatic wr_seq(input int addr16, input int n);
    logic [7:0] r; bit oe;
    cs_lo(); xfer(8'h02, r, oe);
    xfer(addr16[15:8], r, oe); xfer(addr16[7:0], r, oe);
    for (int i = 0; i < n; i++) xfer(wbuf[i], r, oe);
    cs_hi();
  endtask

  function automatic bit lk(input int a, input int lvl);
    return (lvl == 3) || (lvl == 2 && a >= 512) || (lvl == 1 && a >= 768);
  endfunction

  // Model of an accepted page write: offsets wrap inside the 32-byte page.
  function automatic void model_write(input int a, input int n);
    for (int i = 0; i < n; i++)
      model[(a & ~31) + ((a + i) % 32)] = wbuf[i];
  endfunction

  task automatic rd_cmp(input int addr16, input int n, input string req);
    logic [7:0] r, first_act, first_exp; bit oe, all_oe; int bad;
    int a;
    bad = 0; all_oe = 1; a = addr16 % 1024;
    first_act = 0; first_exp = 0;
    cs_lo(); xfer(8'h03, r, oe);
    xfer(addr16[15:8], r, oe); xfer(addr16[7:0], r, oe);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, r, oe);
      all_oe &= oe;
      if (r !== model[(a + i) % 1024]) begin
        if (bad == 0) begin first_act = r; first_exp = model[(a + i) % 1024]; end
        bad++;
      end
    end
    cs_hi();
    chk(bad == 0 && all_oe, req, int'(first_act), int'(first_exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, r;
    bit oe, any_oe;
    int t0, el;
    for (int i = 0; i < 1024; i++) model[i] = 8'hFF;
    rst_n = 0; sel_n = 1; sclk = 0; mosi = 0; wprot_n = 1; pause_n = 1;
    tick(5); rst_n = 1; tick(3);

    // R12 reset state
    chk(miso_oe == 1'b0, "R12 output idle", int'(miso_oe), 0);
    rd_stat(s); chk(s == 8'h00, "R12 status", s, 8'h00);
    rd_cmp(0, 8, "R12 array erased");

    // R3 write without arming
    wbuf[0] = 8'h3C; wr_seq(100, 1);
    rd_stat(s); chk(s == 8'h00, "R3 no cycle started", s, 8'h00);
    rd_cmp(100, 1, "R3 byte untouched");

    // R2 arm / disarm
    cmd1(8'h06); rd_stat(s); chk(s == 8'h02, "R2 armed bit", s, 8'h02);
    cmd1(8'h04); rd_stat(s); chk(s == 8'h00, "R2 disarmed", s, 8'h00);

    // R5 R6 page write wrapping inside page 96..127
    for (int i = 0; i < 10; i++) wbuf[i] = 8'(8'hA0 + i);
    cmd1(8'h06); wr_seq(124, 10); t0 = cyc;
    rd_stat(s); chk(s == 8'h03, "R6 busy and armed after select rise", s, 8'h03);
    wait_ready(); el = cyc - t0;
    chk(el >= WRC && el <= WRC + 300, "R6 cycle length", el, WRC);
    rd_stat(s); chk(s == 8'h00, "R6 armed bit cleared", s, 8'h00);
    model_write(124, 10);
    rd_cmp(90, 44, "R5 page wrap contents");

    // R7 busy ignores reads
    wbuf[0] = 8'h77; cmd1(8'h06); wr_seq(200, 1);
    cs_lo(); xfer(8'h03, r, oe); any_oe = oe; xfer(8'h00, r, oe); any_oe |= oe;
    xfer(8'd200, r, oe); any_oe |= oe; xfer(8'h00, r, oe); any_oe |= oe; cs_hi();
    chk(!any_oe, "R7 read refused while busy", int'(any_oe), 0);
    rd_stat(s); chk(s[0] == 1'b1, "R7 status read while busy", s, 8'h03);
    wait_ready(); model_write(200, 1);
    rd_cmp(200, 1, "R7 write landed");

    // R4 rollover and high address bits ignored
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; cmd1(8'h06); wr_seq(1022, 2); wait_ready();
    model_write(1022, 2);
    wbuf[0] = 8'h5E; cmd1(8'h06); wr_seq(0, 1); wait_ready(); model_write(0, 1);
    rd_cmp(16'hFC00 + 1022, 4, "R4 rollover 1023 to 0");

    // R8 guard level sweep against every quarter
    for (int lvl = 0; lvl < 4; lvl++) begin
      cmd1(8'h06); wr_stat(8'(lvl << 2)); wait_ready();
      rd_stat(s); chk(s == 8'(lvl << 2), "R8 guard level stored", s, lvl << 2);
      for (int q = 0; q < 4; q++) begin
        int a;
        a = q * 256 + 40 + lvl;
        wbuf[0] = 8'((lvl << 4) | q);
        cmd1(8'h06); wr_seq(a, 1); wait_ready(); cmd1(8'h04);
        if (!lk(a, lvl)) model_write(a, 1);
        rd_cmp(a, 1, "R8 quarter probe");
      end
    end
    cmd1(8'h06); wr_stat(8'h00); wait_ready();

    // R9 pin lock
    cmd1(8'h06); wr_stat(8'h80); wait_ready();
    rd_stat(s); chk(s == 8'h80, "R9 pin-lock set", s, 8'h80);
    wprot_n = 0; cmd1(8'h06); wr_stat(8'h8C); wait_ready();
    rd_stat(s); chk(s == 8'h82, "R9 status write blocked", s, 8'h82);
    wprot_n = 1; wr_stat(8'h00); wait_ready();
    rd_stat(s); chk(s == 8'h00, "R9 pin high allows", s, 8'h00);
    wprot_n = 0; cmd1(8'h06); wr_stat(8'h04); wait_ready();
    rd_stat(s); chk(s == 8'h04, "R9 pin ignored when lock clear", s, 8'h04);
    cmd1(8'h06); wr_stat(8'h00); wait_ready(); wprot_n = 1;

    // R11 unknown opcode
    cmd1(8'h06);
    cs_lo(); xfer(8'hA5, r, oe); any_oe = oe; xfer(8'h04, r, oe); any_oe |= oe;
    xfer(8'h00, r, oe); any_oe |= oe; cs_hi();
    chk(!any_oe, "R11 output stays off", int'(any_oe), 0);
    rd_stat(s); chk(s == 8'h02, "R11 rest of frame ignored", s, 8'h02);

    // R5 trailing partial byte cancels the write
    cs_lo(); xfer(8'h02, r, oe); xfer(8'h01, r, oe); xfer(8'h2C, r, oe);
    xfer(8'h5A, r, oe);
    for (int b = 0; b < 4; b++) begin sclk = 0; mosi = 1; tick(HALF); sclk = 1; tick(HALF); end
    cs_hi();
    rd_stat(s); chk(s == 8'h02, "R5 partial byte no cycle", s, 8'h02);
    rd_cmp(300, 1, "R5 partial byte contents");
    cmd1(8'h04);

    // R10 pause in the middle of a data byte
    begin
      logic [7:0] got; bit paused_oe;
      paused_oe = 0;
      cs_lo(); xfer(8'h03, r, oe); xfer(8'h00, r, oe); xfer(8'd96, r, oe);
      for (int b = 7; b >= 0; b--) begin
        sclk = 0; mosi = 0; tick(HALF);
        got[b] = miso;
        if (b == 4) begin
          pause_n = 0; tick(2);
          paused_oe |= miso_oe;
          for (int k = 0; k < 3; k++) begin
            sclk = 1; mosi = 1; tick(HALF); paused_oe |= miso_oe;
            sclk = 0; tick(HALF); paused_oe |= miso_oe;
          end
          pause_n = 1; tick(2);
          got[b] = miso;
        end
        sclk = 1; tick(HALF);
      end
      xfer(8'h00, r, oe);
      cs_hi();
      chk(!paused_oe, "R10 output floats while paused", int'(paused_oe), 0);
      chk(got == model[96], "R10 byte resumes", got, model[96]);
      chk(r == model[97], "R10 next byte", r, model[97]);
    end

    // R1 idle-high clock
    cpol = 1'b1; sclk = 1'b1; tick(4);
    rd_cmp(96, 6, "R1 mode 3 read");
    wbuf[0] = 8'hC3; wbuf[1] = 8'h3C; cmd1(8'h06); wr_seq(500, 2); wait_ready();
    model_write(500, 2);
    rd_stat(s); chk(s == 8'h00, "R1 mode 3 status", s, 8'h00);
    rd_cmp(498, 6, "R1 mode 3 write");
    cpol = 1'b0; sclk = 1'b0; tick(4);
    rd_cmp(124, 4, "R1 mode 0 msb first");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule